// File: doc/BRIEF.md
# Compare-and-reload event timer

This block is one timer channel. It counts ticks, compares the live count against a programmable compare value and, when they match, either reloads a programmable load value on the following tick or keeps counting. A sticky flag records each compare match and another records each wraparound of the counter. Each flag drives an interrupt request through its own enable. In pulse mode a timer output pin marks every compare match for one clock cycle.

Ticks come from one of two sources, picked by a select input. The first is an internal source that fires on every second system clock edge. The second is an external, already-prescaled tick strobe that is synchronous to the clock.

Timer operation needs the enable input high and a mode code of 0000 (plain timer) or 0001 (timer with output pulse). Any other mode code holds the counter idle. The control sequence is run by a four-state machine:

- **IDLE**: the counter is cleared.
- **ARMED**: the timer is enabled and waits for the first tick.
- **RUN**: the timer counts.
- **MATCHED**: the last tick produced a compare match.

The transitions are:

- **arm**: IDLE to ARMED, when the timer becomes active.
- **first load**: ARMED to RUN, on the first tick.
- **hit**: to MATCHED, on any tick whose new count equals the compare value.
- **continue**: to RUN, on a tick without a match.
- **stop**: to IDLE from any state, when the enable input is low or the mode code is invalid.

Top module: `evt_timer`

## Requirements
- R1: While reset is asserted and after it is released, the count, both flags, both interrupt requests and the timer output are all zero.
- R2: When the enable input is high and the mode code is 0000 or 0001, the count is zero until the first tick. The first tick loads the load value, not an incremented count.
- R3: With the source select at 0, ticks occur on every second clock edge while the timer is armed or running, and the first tick falls on the second edge in the ARMED state. With the source select at 1, every clock edge that sees the external tick input high is a tick.
- R4: Each later tick adds one to the count, modulo 2^CNT_W.
- R5: On the clock edge where the count takes a value equal to the compare value, the compare flag is set. It then stays set until it is cleared as R10 describes.
- R6: On the tick that follows a compare match, the count takes the load value if the reload input is 1. If the reload input is 0, the count increments.
- R7: An increment from all ones to zero sets the overflow flag, which is sticky in the same way as the compare flag.
- R8: The compare interrupt request equals the compare flag ANDed with its enable input. The overflow interrupt request equals the overflow flag ANDed with its enable input. Both are combinational.
- R9: In mode 0001 the timer output is high for the one clock cycle that follows each match edge. In mode 0000 it stays low.
- R10: A high clear-strobe input clears its flag at the next edge, unless a set event happens on that same edge, in which case the flag stays set. With the enable input low, the count and both flags are zero after the next edge.
- R11: With any mode code other than 0000 and 0001 (including the watchdog codes 1001 and 1010 and the reserved codes 1011 to 1111), the count stays zero, no flag is set and the timer output stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_en | input | 1 | Timer enable |
| mode_sel | input | 4 | Mode code |
| src_ext | input | 1 | Tick source: 0 = clock divided by two, 1 = external tick |
| ext_tick | input | 1 | External prescaled tick strobe, synchronous to clk |
| reload_en | input | 1 | Reload the load value on the tick after a match |
| cmp_irq_en | input | 1 | Compare interrupt enable |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| load_val | input | CNT_W | Load value |
| cmp_val | input | CNT_W | Compare value |
| cmp_flag_clr | input | 1 | Write-one-to-clear strobe for the compare flag |
| ovf_flag_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| count | output | CNT_W | Live counter value |
| cmp_flag | output | 1 | Sticky compare flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_irq | output | 1 | Compare interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |
| tmr_out | output | 1 | Timer output pin |

## Verification
The assertions assume that every input is synchronous to the clock and settles before each rising edge. They also assume that the external tick is a plain per-cycle level, with no hidden pulse-width rule. The bench drives every input on the falling edge, so each one is stable at the sampling edge, and it generates the external tick and both clear strobes from a free-running shift register. The mode code, load value and compare value change only while the enable input is low. A configuration change therefore always passes through IDLE before the next arm.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_RUN,
        ST_MATCHED
    } tmr_state_e;

    localparam logic [3:0] MODE_PLAIN = 4'b0000;
    localparam logic [3:0] MODE_PULSE = 4'b0001;

    function automatic logic mode_valid(input logic [3:0] m);
        return (m == MODE_PLAIN) || (m == MODE_PULSE);
    endfunction

endpackage

// File: rtl/evt_tick_src.sv
module evt_tick_src (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic src_ext,
    input  logic ext_tick,
    output logic tick
);

    logic div_q;

    // Half-rate phase: restarts at zero whenever the channel is not counting.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= 1'b0;
        end else if (run) begin
            div_q <= ~div_q;
        end else begin
            div_q <= 1'b0;
        end
    end

    assign tick = src_ext ? ext_tick : div_q;

    // R3: an internal tick is never followed by another on the next edge
    a_r3_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (!src_ext && tick) |=> !div_q);

endmodule

// File: rtl/evt_count_fsm.sv
module evt_count_fsm
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             tick,
    input  logic             reload_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             running,
    output logic             cmp_hit,
    output logic             wrap_hit
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   inc;

    assign inc = {1'b0, cnt_q} + {1'b0, ONE};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state, next count and event outputs
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        cmp_hit  = 1'b0;
        wrap_hit = 1'b0;
        if (!active) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_ARMED;
                    cnt_d   = '0;
                end
                ST_ARMED: begin
                    if (tick) cnt_d = load_val;
                end
                ST_RUN: begin
                    if (tick) begin
                        cnt_d    = inc[CNT_W-1:0];
                        wrap_hit = inc[CNT_W];
                    end
                end
                ST_MATCHED: begin
                    if (tick) begin
                        if (reload_en) begin
                            cnt_d = load_val;
                        end else begin
                            cnt_d    = inc[CNT_W-1:0];
                            wrap_hit = inc[CNT_W];
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
            if (tick && state_q != ST_IDLE) begin
                cmp_hit = (cnt_d == cmp_val);
                state_d = cmp_hit ? ST_MATCHED : ST_RUN;
            end
        end
    end

    assign count   = cnt_q;
    assign running = (state_q != ST_IDLE);

    // R2: the first tick after arming loads the load value
    a_r2_first_load: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && active && tick) |=> (cnt_q == $past(load_val)));

    // R4: a tick in RUN adds one
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && active && tick) |=> (cnt_q == $past(cnt_q) + ONE));

    // R11: an inactive channel sits in IDLE with a zero count
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (cnt_q == '0 && state_q == ST_IDLE));

endmodule

// File: rtl/evt_flags.sv
module evt_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic tmr_en,
    input  logic pulse_mode,
    input  logic cmp_hit,
    input  logic wrap_hit,
    input  logic cmp_flag_clr,
    input  logic ovf_flag_clr,
    input  logic cmp_irq_en,
    input  logic ovf_irq_en,
    output logic cmp_flag,
    output logic ovf_flag,
    output logic cmp_irq,
    output logic ovf_irq,
    output logic tmr_out
);

    logic cmp_q, ovf_q, out_q;

    // Set wins over clear; disable clears both flags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= 1'b0;
            ovf_q <= 1'b0;
            out_q <= 1'b0;
        end else begin
            if (!tmr_en)           cmp_q <= 1'b0;
            else if (cmp_hit)      cmp_q <= 1'b1;
            else if (cmp_flag_clr) cmp_q <= 1'b0;

            if (!tmr_en)           ovf_q <= 1'b0;
            else if (wrap_hit)     ovf_q <= 1'b1;
            else if (ovf_flag_clr) ovf_q <= 1'b0;

            out_q <= cmp_hit && pulse_mode;
        end
    end

    assign cmp_flag = cmp_q;
    assign ovf_flag = ovf_q;
    assign cmp_irq  = cmp_q & cmp_irq_en;
    assign ovf_irq  = ovf_q & ovf_irq_en;
    assign tmr_out  = out_q;

    // R5: the compare flag holds without a clear
    a_r5_cmp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_q && tmr_en && !cmp_flag_clr) |=> cmp_q);

    // R7: the overflow flag holds without a clear
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && tmr_en && !ovf_flag_clr) |=> ovf_q);

    // R9: the output pulse appears only with a set compare flag
    a_r9_out_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_q |-> cmp_q);

    // R10: disable empties both flags
    a_r10_disable_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en |=> (!cmp_q && !ovf_q));

endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_en,
    input  logic [3:0]       mode_sel,
    input  logic             src_ext,
    input  logic             ext_tick,
    input  logic             reload_en,
    input  logic             cmp_irq_en,
    input  logic             ovf_irq_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cmp_flag_clr,
    input  logic             ovf_flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             cmp_flag,
    output logic             ovf_flag,
    output logic             cmp_irq,
    output logic             ovf_irq,
    output logic             tmr_out
);

    logic active, running, tick, cmp_hit, wrap_hit;

    assign active = tmr_en && mode_valid(mode_sel);

    evt_tick_src u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running && active),
        .src_ext  (src_ext),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    evt_count_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .tick      (tick),
        .reload_en (reload_en),
        .load_val  (load_val),
        .cmp_val   (cmp_val),
        .count     (count),
        .running   (running),
        .cmp_hit   (cmp_hit),
        .wrap_hit  (wrap_hit)
    );

    evt_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .tmr_en       (tmr_en),
        .pulse_mode   (mode_sel == MODE_PULSE),
        .cmp_hit      (cmp_hit),
        .wrap_hit     (wrap_hit),
        .cmp_flag_clr (cmp_flag_clr),
        .ovf_flag_clr (ovf_flag_clr),
        .cmp_irq_en   (cmp_irq_en),
        .ovf_irq_en   (ovf_irq_en),
        .cmp_flag     (cmp_flag),
        .ovf_flag     (ovf_flag),
        .cmp_irq      (cmp_irq),
        .ovf_irq      (ovf_irq),
        .tmr_out      (tmr_out)
    );

endmodule

// File: tb/evt_timer_bench.sv
`timescale 1ns/1ps
module evt_timer_bench;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tmr_en = 1'b0;
    logic [3:0]   mode_sel = 4'd0;
    logic         src_ext = 1'b0;
    logic         ext_tick = 1'b0;
    logic         reload_en = 1'b0;
    logic         cmp_irq_en = 1'b0;
    logic         ovf_irq_en = 1'b0;
    logic [W-1:0] load_val = '0;
    logic [W-1:0] cmp_val = '0;
    logic         cmp_flag_clr = 1'b0;
    logic         ovf_flag_clr = 1'b0;
    logic [W-1:0] count;
    logic         cmp_flag, ovf_flag, cmp_irq, ovf_irq, tmr_out;

    int checks = 0;
    int failures = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    evt_timer #(.CNT_W(W)) u_evt_timer (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .mode_sel(mode_sel),
        .src_ext(src_ext), .ext_tick(ext_tick), .reload_en(reload_en),
        .cmp_irq_en(cmp_irq_en), .ovf_irq_en(ovf_irq_en),
        .load_val(load_val), .cmp_val(cmp_val),
        .cmp_flag_clr(cmp_flag_clr), .ovf_flag_clr(ovf_flag_clr),
        .count(count), .cmp_flag(cmp_flag), .ovf_flag(ovf_flag),
        .cmp_irq(cmp_irq), .ovf_irq(ovf_irq), .tmr_out(tmr_out)
    );

    // Expected behaviour built from the requirements
    int           m_st;     // 0 idle, 1 armed, 2 counting, 3 just matched
    logic         m_div;
    logic [W-1:0] m_cnt;
    logic         m_cf, m_of, m_out;

    always @(posedge clk or negedge rst_n) begin : model
        logic act, tk, hit, wr;
        logic [W-1:0] nc;
        logic [W:0] inc;
        int ns;
        if (!rst_n) begin
            m_st <= 0; m_div <= 1'b0; m_cnt <= '0;
            m_cf <= 1'b0; m_of <= 1'b0; m_out <= 1'b0;
        end else begin
            act = tmr_en && (mode_sel == 4'd0 || mode_sel == 4'd1);   // R11
            tk  = src_ext ? ext_tick : m_div;                         // R3
            hit = 1'b0; wr = 1'b0; nc = m_cnt; ns = m_st;
            if (!act) begin
                ns = 0; nc = '0;
            end else if (m_st == 0) begin
                ns = 1;
            end else if (tk) begin
                if (m_st == 1 || (m_st == 3 && reload_en)) begin      // R2 R6
                    nc = load_val;
                end else begin                                        // R4
                    inc = {1'b0, m_cnt} + 1;
                    nc = inc[W-1:0];
                    wr = inc[W];
                end
                hit = (nc == cmp_val);
                ns = hit ? 3 : 2;
            end
            m_div <= (act && m_st != 0) ? ~m_div : 1'b0;
            m_st  <= ns;
            m_cnt <= nc;
            if (!tmr_en) m_cf <= 1'b0;
            else if (hit) m_cf <= 1'b1;
            else if (cmp_flag_clr) m_cf <= 1'b0;
            if (!tmr_en) m_of <= 1'b0;
            else if (wr) m_of <= 1'b1;
            else if (ovf_flag_clr) m_of <= 1'b0;
            m_out <= hit && (mode_sel == 4'd1);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2 R4 R6 count", 32'(count), 32'(m_cnt));
        chk("R5 R10 cmp_flag", 32'(cmp_flag), 32'(m_cf));
        chk("R7 R10 ovf_flag", 32'(ovf_flag), 32'(m_of));
        chk("R8 cmp_irq", 32'(cmp_irq), 32'(m_cf & cmp_irq_en));
        chk("R8 ovf_irq", 32'(ovf_irq), 32'(m_of & ovf_irq_en));
        chk("R9 tmr_out", 32'(tmr_out), 32'(m_out));
    endtask

    // One cycle: compare at the falling edge, then drive new stimulus.
    task automatic step(input bit rnd);
        @(negedge clk);
        compare_all();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ext_tick     = rnd ? lfsr[0] : 1'b1;
        cmp_flag_clr = rnd && (lfsr[5:3] == 3'b000);
        ovf_flag_clr = rnd && (lfsr[9:7] == 3'b000);
        cmp_irq_en   = lfsr[11];
        ovf_irq_en   = lfsr[12];
    endtask

    task automatic run_case(input logic [3:0] md, input bit src, input bit rl,
                            input logic [W-1:0] ld, input logic [W-1:0] cp,
                            input int n, input bit rnd);
        @(negedge clk);
        tmr_en = 1'b0; cmp_flag_clr = 1'b0; ovf_flag_clr = 1'b0;
        step(rnd);
        mode_sel = md; src_ext = src; reload_en = rl; load_val = ld; cmp_val = cp;
        tmr_en = 1'b1;
        for (int i = 0; i < n; i++) step(rnd);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 count", 32'(count), 0);
        chk("R1 flags", 32'({cmp_flag, ovf_flag, cmp_irq, ovf_irq, tmr_out}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'({count, cmp_flag, ovf_flag, tmr_out}), 0);

        // R3: internal half-rate source, first load on second armed edge
        mode_sel = 4'd0; src_ext = 1'b0; load_val = 4'd9; cmp_val = 4'd0;
        reload_en = 1'b0; tmr_en = 1'b1;
        @(negedge clk); chk("R3 armed count", 32'(count), 0);  // edge 1: armed
        @(negedge clk); chk("R3 no tick yet", 32'(count), 0);  // edge 2
        @(negedge clk); chk("R2 R3 first load", 32'(count), 9); // edge 3: tick
        @(negedge clk); chk("R3 no tick odd", 32'(count), 9);
        @(negedge clk); chk("R4 increment", 32'(count), 10);
        tmr_en = 1'b0;
        @(negedge clk); chk("R10 disable clears count", 32'(count), 0);

        // R11: every non-timer mode code stays idle
        for (int md = 2; md < 16; md++) begin
            @(negedge clk);
            mode_sel = 4'(md); src_ext = 1'b1; ext_tick = 1'b1;
            load_val = 4'd3; cmp_val = 4'd3; tmr_en = 1'b1;
            repeat (20) @(negedge clk);
            chk("R11 count held", 32'(count), 0);
            chk("R11 no flags or output", 32'({cmp_flag, ovf_flag, tmr_out}), 0);
            tmr_en = 1'b0;
        end
        @(negedge clk);

        // R10: set beats clear on the same edge (load equals compare, reload)
        mode_sel = 4'd1; src_ext = 1'b1; ext_tick = 1'b1; reload_en = 1'b1;
        load_val = 4'd5; cmp_val = 4'd5; tmr_en = 1'b1;
        @(negedge clk);
        cmp_flag_clr = 1'b1;
        @(negedge clk);
        chk("R10 set wins over clear", 32'(cmp_flag), 1);
        chk("R9 pulse after match", 32'(tmr_out), 1);
        tmr_en = 1'b0; cmp_flag_clr = 1'b0;
        @(negedge clk);

        // Sweep: every load/compare pair, both reload settings, external ticks
        for (int rl = 0; rl < 2; rl++)
            for (int ld = 0; ld < 16; ld++)
                for (int cp = 0; cp < 16; cp++)
                    run_case(4'((ld + cp) & 1), 1'b1, rl[0], 4'(ld), 4'(cp), 40, 1'b1);

        // Sweep: internal half-rate source over a subset
        for (int rl = 0; rl < 2; rl++)
            for (int md = 0; md < 2; md++)
                for (int cp = 0; cp < 16; cp += 3)
                    run_case(4'(md), 1'b0, rl[0], 4'(cp ^ 4'd6), 4'(cp), 80, 1'b1);

        // Steady ext tick every cycle: long run covering wrap (R7) and repeated matches
        run_case(4'd1, 1'b1, 1'b0, 4'd14, 4'd2, 60, 1'b0);
        run_case(4'd0, 1'b1, 1'b1, 4'd11, 4'd15, 60, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule